// File: doc/BRIEF.md
# Digital Volume Mute Soft-Ramp Controller

This block is a gain stage for one channel of a signed audio sample stream that feeds a DAC. The gain is set in the log domain. A channel volume code and a master volume code are added together. Each code step is one sixteenth of a doubling, about 0.376 dB, so the linear gain is 2^(code/16). The sum is clamped at +16 steps. Any sum below a floor parameter turns into full mute, which is an exact zero output. The default floor is -239 steps, about -90 dB. A floor of -220 steps gives about -83 dB. A bypass bit leaves the master code out of the sum.

Four sources can force mute: a mute bit, a power-down bit and a noise-gate flag, with the below-floor sum as the fourth. All four share one transition path. When the soft-ramp enable is clear, every change of the gain code takes effect at once. When it is set, the applied code moves one step toward the target every 1, 2, 4 or 8 accepted samples, and it stops on the target. A low-latency input makes every change immediate, whatever the soft-ramp bit says. An invert bit negates the output polarity.

Samples enter and leave through a valid/ready pair. One output register sits between them.

Top module: `dvol_gain`

## Requirements
- R1: After reset `out_valid_o` is 0, `in_ready_o` is 1, and the applied gain code is the mute code. With soft ramp on, the first sample accepted after reset comes out as 0.
- R2: For an applied code c, the output is in·M[c mod 16]·2^(floor(c/16)−15), rounded half toward +infinity. M[m] is round(2^15·2^(m/16)). For example, code 0 gives in, code 16 gives 2·in, and code −16 with input 1001 gives 501.
- R3: The target code is ch_vol_i + mst_vol_i, both 9-bit two's complement. When `mst_bypass_i` is 1, the target is ch_vol_i alone.
- R4: A sum above +16 is clamped to +16.
- R5: A sum equal to FLOOR_CODE (default −239) gives a nonzero, attenuated result. A sum below FLOOR_CODE gives an output of exactly 0.
- R6: Any one of `mute_i`, `pdn_i` or `gate_i` at 1 sets the target to mute, so an immediate-mode sample comes out as 0.
- R7: With `soft_en_i`=0, a new target applies to the sample accepted in the same cycle.
- R8: With `soft_en_i`=1, the applied code moves by exactly one step toward the target after every 2^rate_i accepted samples. Samples 0 to 2^rate_i−1 after a change use the old code. The code stops exactly at the target.
- R9: With `low_lat_i`=1, changes are immediate even when `soft_en_i`=1.
- R10: With `invert_i`=1, the rounded result is negated before saturation. For example, −8388608 comes out as 8388607, and code −16 with input 1001 gives −501.
- R11: Results are saturated to the 24-bit signed range.
- R12: `in_ready_o` = !out_valid_o || out_ready_i. The result appears on `out_valid_o`/`out_data_o` one cycle after it is accepted, and it holds stable while `out_ready_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_vol_i | input | 9 | Channel volume code, signed steps |
| mst_vol_i | input | 9 | Master volume code, signed steps |
| mst_bypass_i | input | 1 | Leave master code out of the sum |
| mute_i | input | 1 | Mute bit |
| pdn_i | input | 1 | Power-down bit |
| gate_i | input | 1 | Noise-gate flag from outside the block |
| soft_en_i | input | 1 | Soft-ramp enable |
| rate_i | input | 2 | Ramp interval, 2^rate_i samples per step |
| low_lat_i | input | 1 | Force immediate transitions |
| invert_i | input | 1 | Negate output polarity |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample ready |
| in_data_i | input | 24 | Input sample, signed |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Output sample ready |
| out_data_o | output | 24 | Output sample, signed |

## Verification
Each result is due on the clock edge that follows the edge at which its sample is accepted. The bench therefore drives a sample on a falling edge and reads the output on the next falling edge. In immediate mode a new setting applies to the sample accepted together with it, so settings and the sample change on the same falling edge. Ramp positions are counted in accepted samples, not in clocks: the bench checks sample indices 0, 2^rate−1, 2^rate and the samples after the code reaches the target. Stall checks read the held output on two later falling edges.

// File: rtl/dvol_pkg.sv
package dvol_pkg;
  localparam int FRAC_BITS = 15;
  localparam int MANT_W    = 17;  // signed container for an unsigned Q1.15 mantissa

  // round(2^15 * 2^(m/16))
  function automatic logic [15:0] mant_lut(input logic [3:0] m);
    case (m)
      4'd0:  mant_lut = 16'd32768;
      4'd1:  mant_lut = 16'd34219;
      4'd2:  mant_lut = 16'd35734;
      4'd3:  mant_lut = 16'd37316;
      4'd4:  mant_lut = 16'd38968;
      4'd5:  mant_lut = 16'd40693;
      4'd6:  mant_lut = 16'd42495;
      4'd7:  mant_lut = 16'd44376;
      4'd8:  mant_lut = 16'd46341;
      4'd9:  mant_lut = 16'd48393;
      4'd10: mant_lut = 16'd50535;
      4'd11: mant_lut = 16'd52773;
      4'd12: mant_lut = 16'd55109;
      4'd13: mant_lut = 16'd57549;
      4'd14: mant_lut = 16'd60097;
      default: mant_lut = 16'd62757;
    endcase
  endfunction
endpackage

// File: rtl/dvol_target.sv
module dvol_target #(
  parameter int REG_W      = 9,
  parameter int CODE_W     = REG_W + 1,
  parameter int MAX_CODE   = 16,
  parameter int FLOOR_CODE = -239
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [REG_W-1:0]  ch_vol_i,
  input  logic signed [REG_W-1:0]  mst_vol_i,
  input  logic                     mst_bypass_i,
  input  logic                     mute_i,
  input  logic                     pdn_i,
  input  logic                     gate_i,
  output logic signed [CODE_W-1:0] tgt_o
);
  localparam int MUTE_CODE = FLOOR_CODE - 1;

  logic signed [CODE_W-1:0] sum;

  always_comb begin
    sum = CODE_W'(ch_vol_i) + (mst_bypass_i ? '0 : CODE_W'(mst_vol_i));
    if (mute_i || pdn_i || gate_i) tgt_o = CODE_W'(MUTE_CODE);
    else if (sum > CODE_W'(MAX_CODE)) tgt_o = CODE_W'(MAX_CODE);
    else if (sum < CODE_W'(FLOOR_CODE)) tgt_o = CODE_W'(MUTE_CODE);
    else tgt_o = sum;
  end

  p_tgt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o <= CODE_W'(MAX_CODE)) &&
    (tgt_o >= CODE_W'(FLOOR_CODE) || tgt_o == CODE_W'(MUTE_CODE)));

  p_mute_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_i || pdn_i || gate_i) |-> tgt_o == CODE_W'(MUTE_CODE));
endmodule

// File: rtl/dvol_ramp.sv
module dvol_ramp #(
  parameter int CODE_W     = 10,
  parameter int RATE_W     = 2,
  parameter int FLOOR_CODE = -239
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [CODE_W-1:0] tgt_i,
  input  logic                     imm_i,
  input  logic                     step_en_i,
  input  logic [RATE_W-1:0]        rate_i,
  output logic signed [CODE_W-1:0] code_o
);
  localparam int MUTE_CODE = FLOOR_CODE - 1;
  localparam int CNT_W     = (1 << RATE_W) - 1;

  logic signed [CODE_W-1:0] cur_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [CNT_W-1:0]         lim;

  assign lim    = CNT_W'((1 << rate_i) - 1);
  assign code_o = imm_i ? tgt_i : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= CODE_W'(MUTE_CODE);
      cnt_q <= '0;
    end else if (imm_i) begin
      cur_q <= tgt_i;
      cnt_q <= '0;
    end else if (cur_q == tgt_i) begin
      cnt_q <= '0;
    end else if (step_en_i) begin
      if (cnt_q == lim) begin
        cnt_q <= '0;
        cur_q <= (cur_q < tgt_i) ? cur_q + CODE_W'(1) : cur_q - CODE_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_ramp_unit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !imm_i |=> (cur_q == $past(cur_q) || cur_q == $past(cur_q) + CODE_W'(1) ||
                cur_q == $past(cur_q) - CODE_W'(1)));

  p_ramp_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && !step_en_i) |=> $stable(cur_q));

  p_no_overshoot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && cur_q == tgt_i) |=> cur_q == $past(tgt_i));

  p_imm_track_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_i |=> cur_q == $past(tgt_i));
endmodule

// File: rtl/dvol_apply.sv
module dvol_apply
  import dvol_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int CODE_W     = 10,
  parameter int FLOOR_CODE = -239
) (
  input  logic signed [DATA_W-1:0] din_i,
  input  logic signed [CODE_W-1:0] code_i,
  input  logic                     inv_i,
  output logic signed [DATA_W-1:0] dout_o
);
  localparam int MUTE_CODE = FLOOR_CODE - 1;
  localparam int PROD_W    = DATA_W + MANT_W + 1;
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = -PROD_W'(64'sd1 <<< (DATA_W - 1));

  logic signed [MANT_W-1:0] mant;
  logic signed [PROD_W-1:0] prod, rnd, shd;
  int                       expo, sh;

  always_comb begin
    mant = $signed({1'b0, mant_lut(code_i[3:0])});
    prod = PROD_W'(din_i) * PROD_W'(mant);
    expo = int'(code_i) >>> 4;
    sh   = FRAC_BITS - expo;
    rnd  = (sh > 0) ? prod + (PROD_W'(1) <<< (sh - 1)) : prod;
    shd  = (sh > 0) ? (rnd >>> sh) : (rnd <<< (-sh));
    if (inv_i) shd = -shd;
    if (code_i == CODE_W'(MUTE_CODE)) dout_o = '0;
    else if (shd > MAXV) dout_o = MAXV[DATA_W-1:0];
    else if (shd < MINV) dout_o = MINV[DATA_W-1:0];
    else dout_o = shd[DATA_W-1:0];
  end
endmodule

// File: rtl/dvol_gain.sv
module dvol_gain #(
  parameter int DATA_W     = 24,
  parameter int REG_W      = 9,
  parameter int RATE_W     = 2,
  parameter int MAX_CODE   = 16,
  parameter int FLOOR_CODE = -239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  ch_vol_i,
  input  logic [REG_W-1:0]  mst_vol_i,
  input  logic              mst_bypass_i,
  input  logic              mute_i,
  input  logic              pdn_i,
  input  logic              gate_i,
  input  logic              soft_en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              low_lat_i,
  input  logic              invert_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int CODE_W    = REG_W + 1;
  localparam int MUTE_CODE = FLOOR_CODE - 1;

  logic signed [CODE_W-1:0] tgt, code;
  logic signed [DATA_W-1:0] y;
  logic                     acc, imm;
  logic                     out_valid_q;
  logic [DATA_W-1:0]        out_data_q;

  assign imm         = !soft_en_i || low_lat_i;
  assign in_ready_o  = !out_valid_q || out_ready_i;
  assign acc         = in_valid_i && in_ready_o;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  dvol_target #(.REG_W(REG_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
                .FLOOR_CODE(FLOOR_CODE)) u_target (
    .clk_i, .rst_ni,
    .ch_vol_i(signed'(ch_vol_i)), .mst_vol_i(signed'(mst_vol_i)),
    .mst_bypass_i, .mute_i, .pdn_i, .gate_i,
    .tgt_o(tgt)
  );

  dvol_ramp #(.CODE_W(CODE_W), .RATE_W(RATE_W), .FLOOR_CODE(FLOOR_CODE)) u_ramp (
    .clk_i, .rst_ni, .tgt_i(tgt), .imm_i(imm), .step_en_i(acc),
    .rate_i, .code_o(code)
  );

  dvol_apply #(.DATA_W(DATA_W), .CODE_W(CODE_W), .FLOOR_CODE(FLOOR_CODE)) u_apply (
    .din_i(signed'(in_data_i)), .code_i(code), .inv_i(invert_i), .dout_o(y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (in_ready_o) out_valid_q <= in_valid_i;
      if (acc) out_data_q <= y;
    end
  end

  p_stall_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_floor_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && code == CODE_W'(MUTE_CODE)) |=> out_data_o == '0);

  p_mute_imm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && imm && (mute_i || pdn_i || gate_i)) |=> out_data_o == '0);
endmodule

// File: tb/dvol_gain_bench.sv
module dvol_gain_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] ch_vol = '0, mst_vol = '0;
  logic mst_bypass = 0, mute = 0, pdn = 0, gate = 0, soft_en = 0, low_lat = 0, invert = 0;
  logic [1:0] rate = '0;
  logic in_valid = 0, out_ready = 1;
  logic [23:0] in_data = '0;
  logic in_ready, out_valid;
  logic [23:0] out_data;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dvol_gain u_dvol_gain (
    .clk_i(clk), .rst_ni(rst_n), .ch_vol_i(ch_vol), .mst_vol_i(mst_vol),
    .mst_bypass_i(mst_bypass), .mute_i(mute), .pdn_i(pdn), .gate_i(gate),
    .soft_en_i(soft_en), .rate_i(rate), .low_lat_i(low_lat), .invert_i(invert),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  typedef struct packed {
    logic signed [8:0]  ch;
    logic signed [8:0]  mst;
    logic               byp;
    logic               inv;
    logic signed [23:0] din;
    logic signed [23:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{9'sd0,    9'sd0,   1'b0, 1'b0, 24'sd1000,     24'sd1000},     // R2
    '{9'sd16,   9'sd0,   1'b0, 1'b0, 24'sd1000,     24'sd2000},     // R2
    '{-9'sd16,  9'sd0,   1'b0, 1'b0, 24'sd1001,     24'sd501},      // R2
    '{-9'sd16,  9'sd0,   1'b0, 1'b0, -24'sd1001,    -24'sd500},     // R2
    '{-9'sd32,  9'sd0,   1'b0, 1'b0, -24'sd1000,    -24'sd250},     // R2
    '{9'sd8,    9'sd8,   1'b0, 1'b0, 24'sd1000,     24'sd2000},     // R3
    '{9'sd8,    9'sd8,   1'b1, 1'b0, 24'sd1000,     24'sd1414},     // R3
    '{9'sd16,   9'sd16,  1'b0, 1'b0, 24'sd1000,     24'sd2000},     // R4
    '{9'sd100,  -9'sd50, 1'b0, 1'b0, 24'sd1000,     24'sd2000},     // R4
    '{-9'sd200, -9'sd39, 1'b0, 1'b0, 24'sd4194304,  24'sd134},      // R5
    '{-9'sd200, -9'sd40, 1'b0, 1'b0, 24'sd4194304,  24'sd0},        // R5
    '{9'sd16,   9'sd0,   1'b0, 1'b0, 24'sd8388607,  24'sd8388607},  // R11
    '{9'sd16,   9'sd0,   1'b0, 1'b0, -24'sd8388608, -24'sd8388608}, // R11
    '{9'sd0,    9'sd0,   1'b0, 1'b1, 24'sd1000,     -24'sd1000},    // R10
    '{9'sd0,    9'sd0,   1'b0, 1'b1, -24'sd8388608, 24'sd8388607},  // R10
    '{-9'sd16,  9'sd0,   1'b0, 1'b1, 24'sd1001,     -24'sd501}      // R10
  };
  localparam string TAGS [NV] = '{"R2", "R2", "R2", "R2", "R2", "R3", "R3", "R4",
                                   "R4", "R5", "R5", "R11", "R11", "R10", "R10", "R10"};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_tol(input string req, input int act, input int exp);
    int d, e;
    d = (act > exp) ? act - exp : exp - act;
    e = (exp < 0) ? -exp : exp;
    checks++;
    if (d > 1 + e / 8192) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_gain(input int x, input int c);
    real g;
    g = x * (2.0 ** (c / 16.0));
    return (g >= 0.0) ? $rtoi(g + 0.5) : -$rtoi(-g + 0.5);
  endfunction

  task automatic send(input logic [23:0] x, output int y);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    y = int'(signed'(out_data));
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int y;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R12 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    // R1: applied code starts muted, ramp mode one step per sample
    soft_en = 1'b1;
    rate = 2'd0;
    send(24'sd1000, y);
    chk("R1 first sample", y, 0);
    chk("R12 out_valid", int'(out_valid), 1);

    soft_en = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ch_vol = VECS[i].ch;
      mst_vol = VECS[i].mst;
      mst_bypass = VECS[i].byp;
      invert = VECS[i].inv;
      send(VECS[i].din, y);
      chk(TAGS[i], y, int'(VECS[i].exp));
    end

    // R7: immediate change applies to the same sample
    @(negedge clk);
    ch_vol = 9'sd0; mst_vol = 9'sd0; mst_bypass = 0; invert = 0;
    send(24'sd1000, y);
    chk("R7 immediate", y, 1000);

    // R8: ramp up, one step per 4 samples, stops at +16
    @(negedge clk);
    soft_en = 1'b1; rate = 2'd2; ch_vol = 9'sd16;
    for (int k = 0; k <= 100; k++) begin
      send(24'sd1000, y);
      if (k == 0 || k == 3 || k == 4 || k == 63 || k == 64 || k == 100)
        chk_tol("R8 ramp up", y, ref_gain(1000, (k / 4 > 16) ? 16 : k / 4));
    end

    // R8: ramp down, one step per sample, stops at -16
    @(negedge clk);
    rate = 2'd0; ch_vol = -9'sd16;
    for (int k = 0; k <= 40; k++) begin
      send(24'sd1000, y);
      if (k == 0 || k == 1 || k == 32 || k == 40)
        chk_tol("R8 ramp down", y, ref_gain(1000, (16 - k < -16) ? -16 : 16 - k));
    end

    // R9: low latency overrides soft ramp
    @(negedge clk);
    low_lat = 1'b1; ch_vol = 9'sd0;
    send(24'sd1000, y);
    chk("R9 low latency", y, 1000);

    // R6: each mute source, immediate
    @(negedge clk);
    low_lat = 1'b0; soft_en = 1'b0; mute = 1'b1;
    send(24'sd1000, y);
    chk("R6 mute", y, 0);
    @(negedge clk);
    mute = 1'b0; pdn = 1'b1;
    send(24'sd1000, y);
    chk("R6 pdn", y, 0);
    @(negedge clk);
    pdn = 1'b0; gate = 1'b1;
    send(-24'sd1000, y);
    chk("R6 gate", y, 0);
    @(negedge clk);
    gate = 1'b0;
    send(24'sd1000, y);
    chk("R6 release", y, 1000);

    // R12: stall holds output and drops ready
    @(negedge clk);
    out_ready = 1'b0;
    send(24'sd777, y);
    chk("R12 data", y, 777);
    chk("R12 valid", int'(out_valid), 1);
    @(negedge clk);
    chk("R12 hold", int'(signed'(out_data)), 777);
    chk("R12 ready low", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R12 drained", int'(out_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule